// File: doc/BRIEF.md
# Clause 22 Management Bus Master

This block lets a processor reach the management registers of external PHYs over the two-wire serial management bus (a clock line and a bidirectional data line). Software sees six 32-bit words on a simple synchronous register bus. A frame is started either by writing the 16-bit payload word (a register write to the PHY) or by raising the read bit in the command word (a register read from the PHY). The block then generates the management clock, serializes the full frame, turns the data line around for reads and shifts in the PHY's answer.

Software polls the indication word. The busy flag covers the whole frame. A separate not-valid flag covers a read until its data has landed in the read-data word. A soft-reset bit in the configuration word aborts any frame and frees the data line. The configuration word also holds a 3-bit clock divider select, which resets to 7.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the configuration word reads 0x00000007, the indication word reads 0, the address word reads 0, and both the management clock and the data-line output enable are low.
- R2: Word offsets are: configuration 0x00 (bit 31 soft reset, bits 2:0 divider select), command 0x04 (bit 0 read), address 0x08 (PHY address bits 12:8, register number bits 4:0), write data 0x0C (bits 15:0), read data 0x10 (bits 15:0), indication 0x14. Bits not listed read as zero.
- R3: A bus write to the write-data word latches bits 15:0 and sends 64 bits MSB first, all driven: 32 ones, 01, opcode 01, PHY address, register number, turnaround 10, data. The data line changes after the clock falls.
- R4: A read frame drives 32 ones, 01, opcode 10, PHY address and register number (46 bits). It releases the data line for the last 18 bits and samples the 16 data bits on the rising clock edges. The read-data word then returns them and keeps them until the next read completes.
- R5: Indication bit 0 (busy) is 1 from the start of any frame until it ends. Indication bit 2 (not-valid) is set when a read starts and cleared when its data is stored. Not-valid is never set without busy.
- R6: A read frame starts only when a write turns command bit 0 from 0 to 1. Writing 1 over a stored 1 starts nothing.
- R7: While configuration bit 31 is 1, any frame is aborted, busy and not-valid are cleared, the data line is released and no frame can start.
- R8: The management clock period is 2*(N+1)*4 system clocks, where N is the divider select. The clock stays low while no frame runs.
- R9: While busy is set, writes to the address, write-data and command words change no register and start no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr, one cycle later |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A wrong bit counter or shift register shows up as a wrong captured frame, or as a count of clock rises other than 64. This is visible once the frame ends, at most 64 management clock periods after the start. A stuck busy or not-valid flag shows in the indication word on the next poll, and it also blocks every later frame. Turnaround mistakes show as the output enable being high during the 18 read bits. A lost edge detect on the command bit shows as an extra frame right after a repeated write of 1. A divider error shows in the measured period between two clock rises within the first frame at each select value.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  // word indexes of the register map (byte offset / 4)
  localparam int WIDX_CFG  = 0;
  localparam int WIDX_CMD  = 1;
  localparam int WIDX_ADR  = 2;
  localparam int WIDX_WDAT = 3;
  localparam int WIDX_RDAT = 4;
  localparam int WIDX_IND  = 5;

  localparam int FIELD_AW = 5;   // PHY address and register number width

  localparam logic [1:0] FRM_SOF   = 2'b01;
  localparam logic [1:0] FRM_OP_WR = 2'b01;
  localparam logic [1:0] FRM_OP_RD = 2'b10;
  localparam logic [1:0] FRM_TA_WR = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
  parameter int SEL_W = 3,
  parameter int UNIT  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam int CNT_W = $clog2((2**SEL_W) * UNIT);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             wrap;

  assign half_m1  = CNT_W'((int'(sel) + 1) * UNIT - 1);
  assign wrap     = en && (cnt == half_m1);
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                abort,
  input  logic                start,
  input  logic                start_rd,
  input  logic [FIELD_AW-1:0] phy,
  input  logic [FIELD_AW-1:0] regn,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                rise_stb,
  input  logic                fall_stb,
  input  logic                mdio_i,
  output logic                busy,
  output logic                not_valid,
  output logic                mdio_o,
  output logic                mdio_oe,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int HDR_BITS   = PRE_BITS + 4 + 2 * FIELD_AW;
  localparam int FRAME_BITS = HDR_BITS + 2 + DATA_W;
  localparam int DATA_START = FRAME_BITS - DATA_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame;
  logic [BIT_W-1:0]      idx;
  logic                  is_rd;
  logic [DATA_W-1:0]     cap;

  // read frames carry no payload; the released bits are don't-care
  assign frame = start_rd
      ? {{PRE_BITS{1'b1}}, FRM_SOF, FRM_OP_RD, phy, regn, 2'b00, {DATA_W{1'b0}}}
      : {{PRE_BITS{1'b1}}, FRM_SOF, FRM_OP_WR, phy, regn, FRM_TA_WR, wdata};

  assign mdio_o = shreg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      idx       <= '0;
      is_rd     <= 1'b0;
      busy      <= 1'b0;
      not_valid <= 1'b0;
      mdio_oe   <= 1'b0;
      cap       <= '0;
      rd_data   <= '0;
    end else if (abort) begin
      idx       <= '0;
      busy      <= 1'b0;
      not_valid <= 1'b0;
      mdio_oe   <= 1'b0;
    end else if (start) begin
      shreg     <= frame;
      idx       <= '0;
      is_rd     <= start_rd;
      busy      <= 1'b1;
      not_valid <= start_rd;
      mdio_oe   <= 1'b1;
    end else if (busy) begin
      if (rise_stb && is_rd && idx >= BIT_W'(DATA_START))
        cap <= {cap[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (idx == BIT_W'(FRAME_BITS - 1)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          if (is_rd) begin
            rd_data   <= cap;
            not_valid <= 1'b0;
          end
        end else begin
          shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
          idx   <= idx + 1'b1;
          if (is_rd && idx == BIT_W'(HDR_BITS - 1))
            mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int BUS_AW    = 5,
  parameter int PRE_BITS  = 32,
  parameter int DIV_SEL_W = 3,
  parameter int DIV_UNIT  = 4,
  parameter int DIV_INIT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int IDX_W  = BUS_AW - 2;
  localparam int DATA_W = 16;

  logic [IDX_W-1:0]     widx;
  logic                 cfg_rst_q;
  logic [DIV_SEL_W-1:0] cfg_div_q;
  logic                 cmd_rd_q;
  logic [FIELD_AW-1:0]  phy_q;
  logic [FIELD_AW-1:0]  regn_q;
  logic [DATA_W-1:0]    wdat_q;
  logic                 eng_busy;
  logic                 eng_nv;
  logic [DATA_W-1:0]    eng_rdata;
  logic                 rise_stb;
  logic                 fall_stb;
  logic                 may_write;
  logic                 start_wr;
  logic                 start_rd;
  logic                 unused_bits;

  assign widx      = reg_addr[BUS_AW-1:2];
  assign may_write = reg_we && !eng_busy;
  assign start_wr  = may_write && !cfg_rst_q && widx == IDX_W'(WIDX_WDAT);
  assign start_rd  = may_write && !cfg_rst_q && widx == IDX_W'(WIDX_CMD)
                     && reg_wdata[0] && !cmd_rd_q;
  assign unused_bits = ^{reg_wdata[30:16], reg_addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rst_q <= 1'b0;
      cfg_div_q <= DIV_SEL_W'(DIV_INIT);
      cmd_rd_q  <= 1'b0;
      phy_q     <= '0;
      regn_q    <= '0;
      wdat_q    <= '0;
    end else begin
      if (reg_we && widx == IDX_W'(WIDX_CFG)) begin
        cfg_rst_q <= reg_wdata[31];
        cfg_div_q <= reg_wdata[DIV_SEL_W-1:0];
      end
      if (may_write && widx == IDX_W'(WIDX_CMD))
        cmd_rd_q <= reg_wdata[0];
      if (may_write && widx == IDX_W'(WIDX_ADR)) begin
        phy_q  <= reg_wdata[8+FIELD_AW-1:8];
        regn_q <= reg_wdata[FIELD_AW-1:0];
      end
      if (may_write && widx == IDX_W'(WIDX_WDAT))
        wdat_q <= reg_wdata[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (widx)
        IDX_W'(WIDX_CFG):  reg_rdata <= {cfg_rst_q, {(31-DIV_SEL_W){1'b0}}, cfg_div_q};
        IDX_W'(WIDX_CMD):  reg_rdata <= {31'b0, cmd_rd_q};
        IDX_W'(WIDX_ADR):  reg_rdata <= 32'({phy_q, 3'b000, regn_q});
        IDX_W'(WIDX_WDAT): reg_rdata <= 32'(wdat_q);
        IDX_W'(WIDX_RDAT): reg_rdata <= 32'(eng_rdata);
        IDX_W'(WIDX_IND):  reg_rdata <= {29'b0, eng_nv, 1'b0, eng_busy};
        default:           reg_rdata <= '0;
      endcase
    end
  end

  mdio_mdc_gen #(
    .SEL_W (DIV_SEL_W),
    .UNIT  (DIV_UNIT)
  ) u_mdc (
    .clk      (clk),
    .rst      (rst),
    .en       (eng_busy),
    .sel      (cfg_div_q),
    .mdc      (mdc_o),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_eng #(
    .PRE_BITS (PRE_BITS),
    .DATA_W   (DATA_W)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .abort     (cfg_rst_q),
    .start     (start_wr || start_rd),
    .start_rd  (start_rd),
    .phy       (phy_q),
    .regn      (regn_q),
    .wdata     (reg_wdata[DATA_W-1:0]),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .mdio_i    (mdio_i),
    .busy      (eng_busy),
    .not_valid (eng_nv),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_data   (eng_rdata)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        nv,
  input logic        soft_rst,
  input logic        mdc,
  input logic        oe,
  input logic [15:0] status
);
  p_nv_needs_busy_r5: assert property (@(posedge clk) disable iff (rst)
    nv |-> busy);

  p_oe_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
    oe |-> busy);

  p_soft_abort_r7: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!busy && !nv && !oe));

  p_idle_clock_low_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !mdc);

  p_status_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(status));
endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (eng_busy),
  .nv       (eng_nv),
  .soft_rst (cfg_rst_q),
  .mdc      (mdc_o),
  .oe       (mdio_oe),
  .status   (eng_rdata)
);

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc_o, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // PHY side observation
  int          rise_cnt = 0;
  int          rd_base = 0;
  bit          rd_active = 0;
  logic [15:0] phy_data = '0;
  logic [63:0] cap_bits = '0;
  logic [63:0] cap_oe = '0;
  time         t_prev = 0;
  time         last_period = 0;

  localparam logic [4:0] A_CFG = 5'h00, A_CMD = 5'h04, A_ADR = 5'h08,
                         A_WDAT = 5'h0C, A_RDAT = 5'h10, A_IND = 5'h14;

  // {read, divider select, phy, reg, data}
  localparam logic [29:0] VEC [6] = '{
    {1'b0, 3'd0, 5'h01, 5'h00, 16'h1234},
    {1'b1, 3'd0, 5'h1F, 5'h1F, 16'hA5C3},
    {1'b0, 3'd1, 5'h10, 5'h05, 16'hFFFF},
    {1'b1, 3'd1, 5'h00, 5'h02, 16'h0001},
    {1'b0, 3'd7, 5'h0A, 5'h15, 16'h8000},
    {1'b1, 3'd2, 5'h03, 5'h11, 16'h7FFE}
  };

  always #2.5 clk = ~clk;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc_o) begin
    rise_cnt    = rise_cnt + 1;
    cap_bits    = {cap_bits[62:0], mdio_o};
    cap_oe      = {cap_oe[62:0], mdio_oe};
    last_period = $time - t_prev;
    t_prev      = $time;
  end

  always @(negedge mdc_o) begin
    int k;
    k = rise_cnt - rd_base;
    if (rd_active && k >= 48 && k < 64) mdio_i <= phy_data[63-k];
    else mdio_i <= 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    for (int n = 0; n < 10000; n++) begin
      bus_rd(A_IND, v);
      if (v[0] == 1'b0) return;
    end
    chk(req, 64'(v), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] exp_frame;
    int base;

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 mdc", 64'(mdc_o), 64'h0);
    chk("R1 oe", 64'(mdio_oe), 64'h0);
    bus_rd(A_CFG, v); chk("R1 cfg", 64'(v), 64'h7);
    bus_rd(A_IND, v); chk("R1 ind", 64'(v), 64'h0);
    bus_rd(A_ADR, v); chk("R1 adr", 64'(v), 64'h0);

    // R2 field placement and unused bits
    bus_wr(A_ADR, 32'hFFFF_FFFF);
    bus_rd(A_ADR, v); chk("R2 adr fields", 64'(v), 64'h1F1F);
    bus_wr(A_CFG, 32'h7FFF_FFFD);
    bus_rd(A_CFG, v); chk("R2 cfg fields", 64'(v), 64'h5);

    // vector table: R3 write frames, R4 read frames, R5 flags, R8 period
    for (int i = 0; i < 6; i++) begin
      logic        is_rd;
      logic [2:0]  dv;
      logic [4:0]  ph, rg;
      logic [15:0] dt;
      {is_rd, dv, ph, rg, dt} = VEC[i];
      bus_wr(A_CFG, 32'(dv));
      bus_wr(A_ADR, {19'b0, ph, 3'b0, rg});
      base = rise_cnt; rd_base = rise_cnt; phy_data = dt; rd_active = is_rd;
      if (is_rd) begin
        bus_wr(A_CMD, 32'h0);
        bus_wr(A_CMD, 32'h1);
      end else begin
        bus_wr(A_WDAT, 32'(dt));
      end
      bus_rd(A_IND, v);
      chk("R5 flags during frame", 64'(v), is_rd ? 64'h5 : 64'h1);
      wait_idle("R5 busy clears");
      chk("R3/R4 bit count", 64'(rise_cnt - base), 64'd64);
      chk("R8 period", 64'(last_period), 64'((int'(dv) + 1) * 8 * 5));
      if (is_rd) begin
        exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b10, ph, rg, 18'b0};
        chk("R4 header bits", {cap_bits[63:18], 18'b0}, exp_frame);
        chk("R4 release", cap_oe, {46'h3FFF_FFFF_FFFF, 18'b0});
        bus_rd(A_RDAT, v); chk("R4 read data", 64'(v), 64'(dt));
      end else begin
        exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, ph, rg, 2'b10, dt};
        chk("R3 frame bits", cap_bits, exp_frame);
        chk("R3 drive", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
      end
      bus_rd(A_IND, v); chk("R5 flags after frame", 64'(v), 64'h0);
      chk("R8 clock idle low", 64'(mdc_o), 64'h0);
      rd_active = 0;
    end

    // R6: command bit already 1, writing 1 again must not start a read
    bus_wr(A_CFG, 32'h0);
    base = rise_cnt;
    bus_wr(A_CMD, 32'h1);
    bus_rd(A_IND, v); chk("R6 no frame on repeated 1", 64'(v), 64'h0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R6 no clock", 64'(rise_cnt - base), 64'd0);
    bus_rd(A_RDAT, v); chk("R4 read data held", 64'(v), 64'h7FFE);

    // R9: writes during busy are ignored
    bus_wr(A_ADR, 32'h0000_0203);
    base = rise_cnt;
    bus_wr(A_WDAT, 32'h0000_C0DE);
    bus_wr(A_WDAT, 32'h0000_BEEF);
    bus_wr(A_ADR, 32'h0000_1111);
    bus_wr(A_CMD, 32'h0);
    wait_idle("R9 busy clears");
    chk("R9 frame kept", cap_bits, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h02, 5'h03, 2'b10, 16'hC0DE});
    bus_rd(A_ADR, v); chk("R9 adr kept", 64'(v), 64'h0203);
    bus_rd(A_WDAT, v); chk("R9 wdat kept", 64'(v), 64'hC0DE);
    bus_rd(A_CMD, v); chk("R9 cmd kept", 64'(v), 64'h1);

    // R7: soft reset aborts a read in flight
    bus_wr(A_CMD, 32'h0);
    rd_base = rise_cnt; rd_active = 1; phy_data = 16'h1357;
    bus_wr(A_CMD, 32'h1);
    repeat (100) @(posedge clk);
    bus_wr(A_CFG, 32'h8000_0000);
    bus_rd(A_IND, v); chk("R7 flags cleared", 64'(v), 64'h0);
    chk("R7 line released", 64'(mdio_oe), 64'h0);
    chk("R7 clock low", 64'(mdc_o), 64'h0);
    bus_wr(A_WDAT, 32'h0000_AAAA);
    bus_rd(A_IND, v); chk("R7 no start in reset", 64'(v), 64'h0);
    bus_rd(A_RDAT, v); chk("R7 read data untouched", 64'(v), 64'h7FFE);
    bus_wr(A_CFG, 32'h0);
    rd_active = 0;
    base = rise_cnt;
    bus_wr(A_WDAT, 32'h0000_5A5A);
    wait_idle("R7 recovers");
    chk("R7 frame after reset", cap_bits, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h02, 5'h03, 2'b10, 16'h5A5A});

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule